// File: doc/BRIEF.md
# Control Flow Squash Arbiter

This block sits between the two sources of control-flow redirects in an out-of-order pipeline and the units that act on them. The decode/issue stage raises a redirect for unconditional jumps. The branch execute unit raises one when a conditional branch resolves to a different path. The arbiter keeps only the request that belongs to the oldest instruction and broadcasts it as one squash carrying the target PC and the sequence number of the squashing instruction. The fetch stage uses the broadcast to jump to the new target and throw away its fetches in flight. The decode/issue stage uses it to drop every instruction younger than the squashing one.

Sequence numbers wrap around, so age is never judged by comparing raw numbers. The pipeline supplies the oldest uncommitted sequence number. Each candidate's age is its distance forward from that number, modulo 2^SEQ_W, and a smaller distance means an older instruction. The branch unit resolves each branch in a single cycle, so no wrongly speculated instruction gets past decode/issue, and the arbiter only has to weigh requests raised in the same cycle against the squash it is broadcasting in that cycle.

The control is a two-state machine. In `ST_IDLE` no squash is being broadcast. In `ST_SQUASH` the squash outputs are valid. The *accept* transition (from either state into `ST_SQUASH`) is taken when at least one request survives filtering. The *release* transition (from `ST_SQUASH` to `ST_IDLE`) and the *stay idle* transition (from `ST_IDLE` to `ST_IDLE`) are taken when no request survives.

Top module: `squash_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sq_valid` is 0 and `sq_seq` and `sq_target` are 0.
- R2: A decode request with no branch request, sampled at a clock edge while no squash is being broadcast, appears on the squash outputs (valid, its sequence number, its target) right after that edge.
- R3: A branch request with no decode request, sampled under the same conditions, appears on the squash outputs right after that edge.
- R4: When both sources request in the same cycle, the squash carries the request whose instruction is older.
- R5: Age is computed as (seq − `oldest_seq`) mod 2^SEQ_W, and a smaller value means older. For example, with SEQ_W=4 and `oldest_seq`=14, sequence number 15 is older than sequence number 1.
- R6: When both sources carry the same sequence number, the branch request wins.
- R7: `sq_valid` is high for exactly one cycle per accepted redirect. If no request is accepted at an edge, `sq_valid` is 0 after that edge.
- R8: While a squash is being broadcast, any request whose age is equal to or greater than the broadcast one is ignored.
- R9: While a squash is being broadcast, a request that is strictly older than it is accepted, and it is broadcast in the very next cycle.
- R10: When `sq_valid` is 0, `sq_seq` and `sq_target` hold the values of the last broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oldest_seq | input | SEQ_W | Oldest uncommitted sequence number; the base for age |
| dec_valid | input | 1 | Decode/issue redirect request (jump) |
| dec_seq | input | SEQ_W | Sequence number of the jump |
| dec_target | input | PC_W | Target PC of the jump |
| br_valid | input | 1 | Branch execute unit redirect request |
| br_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| br_target | input | PC_W | Target PC of the branch |
| sq_valid | output | 1 | Squash broadcast, one cycle per accepted redirect |
| sq_seq | output | SEQ_W | Sequence number of the squashing instruction |
| sq_target | output | PC_W | PC to redirect fetch to |

## Verification
The bench builds the block with SEQ_W=4 and PC_W=16. With only sixteen sequence numbers, a short run can place `oldest_seq` near the top of the range, so the cases where modular age and raw numeric order disagree are easy to reach. These cases cover both arbitration between the two sources and filtering against a squash that is already live. The narrow PC width keeps the target values readable, and it still shows that the targets are routed independently of the sequence numbers.

// File: rtl/squash_arb_pkg.sv
package squash_arb_pkg;

    // Two-state controller: broadcasting a squash or not.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SQUASH = 1'b1
    } sq_state_e;

    // Which source, if any, wins arbitration in the current cycle.
    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_BRANCH = 2'd1,
        PICK_DECODE = 2'd2
    } pick_e;

    localparam int NUM_SRC    = 2;
    localparam int SRC_BRANCH = 0;
    localparam int SRC_DECODE = 1;

endpackage

// File: rtl/sq_age_cmp.sv
// Strict age comparison of two sequence numbers, measured from a moving base
// so that wraparound of the sequence space is handled.
module sq_age_cmp #(
    parameter int SEQ_W = 4
) (
    input  logic [SEQ_W-1:0] base,
    input  logic [SEQ_W-1:0] seq_a,
    input  logic [SEQ_W-1:0] seq_b,
    output logic             a_older
);
    logic [SEQ_W-1:0] age_a;
    logic [SEQ_W-1:0] age_b;

    always_comb begin
        age_a   = seq_a - base;
        age_b   = seq_b - base;
        a_older = (age_a < age_b);
    end
endmodule

// File: rtl/sq_pick.sv
// Filters each request against the live squash, then picks the oldest survivor.
module sq_pick
    import squash_arb_pkg::*;
#(
    parameter int SEQ_W = 4
) (
    input  logic [SEQ_W-1:0]              base,
    input  logic                          live_valid,
    input  logic [SEQ_W-1:0]              live_seq,
    input  logic [NUM_SRC-1:0]            req_valid,
    input  logic [NUM_SRC-1:0][SEQ_W-1:0] req_seq,
    output logic [NUM_SRC-1:0]            accept,
    output pick_e                         pick
);
    logic [NUM_SRC-1:0] beats_live;
    logic               dec_over_br;

    // One filter per source: a request survives only if no squash is live,
    // or if it is strictly older than the squash being broadcast.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_filter
        sq_age_cmp #(.SEQ_W(SEQ_W)) u_live_cmp (
            .base    (base),
            .seq_a   (req_seq[s]),
            .seq_b   (live_seq),
            .a_older (beats_live[s])
        );
        assign accept[s] = req_valid[s] && (!live_valid || beats_live[s]);
    end

    // Source against source. A tie goes to the branch unit.
    sq_age_cmp #(.SEQ_W(SEQ_W)) u_src_cmp (
        .base    (base),
        .seq_a   (req_seq[SRC_DECODE]),
        .seq_b   (req_seq[SRC_BRANCH]),
        .a_older (dec_over_br)
    );

    always_comb begin
        pick = PICK_NONE;
        unique case ({accept[SRC_DECODE], accept[SRC_BRANCH]})
            2'b00: pick = PICK_NONE;
            2'b01: pick = PICK_BRANCH;
            2'b10: pick = PICK_DECODE;
            2'b11: pick = dec_over_br ? PICK_DECODE : PICK_BRANCH;
            default: pick = PICK_NONE;
        endcase
    end
endmodule

// File: rtl/sq_fsm.sv
// State register plus registered squash payload.
module sq_fsm
    import squash_arb_pkg::*;
#(
    parameter int SEQ_W = 4,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pick_e            pick,
    input  logic [SEQ_W-1:0] br_seq,
    input  logic [PC_W-1:0]  br_target,
    input  logic [SEQ_W-1:0] dec_seq,
    input  logic [PC_W-1:0]  dec_target,
    output sq_state_e        state,
    output logic [SEQ_W-1:0] sq_seq,
    output logic [PC_W-1:0]  sq_target
);
    sq_state_e state_nxt;

    // Next state: accept / release / stay idle.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   state_nxt = (pick != PICK_NONE) ? ST_SQUASH : ST_IDLE;
            ST_SQUASH: state_nxt = (pick != PICK_NONE) ? ST_SQUASH : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Output payload registers: load on accept, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_seq    <= '0;
            sq_target <= '0;
        end else begin
            unique case (pick)
                PICK_BRANCH: begin
                    sq_seq    <= br_seq;
                    sq_target <= br_target;
                end
                PICK_DECODE: begin
                    sq_seq    <= dec_seq;
                    sq_target <= dec_target;
                end
                default: begin
                    sq_seq    <= sq_seq;
                    sq_target <= sq_target;
                end
            endcase
        end
    end
endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter
    import squash_arb_pkg::*;
#(
    parameter int SEQ_W = 4,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEQ_W-1:0] oldest_seq,
    input  logic             dec_valid,
    input  logic [SEQ_W-1:0] dec_seq,
    input  logic [PC_W-1:0]  dec_target,
    input  logic             br_valid,
    input  logic [SEQ_W-1:0] br_seq,
    input  logic [PC_W-1:0]  br_target,
    output logic             sq_valid,
    output logic [SEQ_W-1:0] sq_seq,
    output logic [PC_W-1:0]  sq_target
);
    logic [NUM_SRC-1:0]            req_valid;
    logic [NUM_SRC-1:0][SEQ_W-1:0] req_seq;
    logic [NUM_SRC-1:0]            accept;
    pick_e                         pick;
    sq_state_e                     state;

    always_comb begin
        req_valid[SRC_BRANCH] = br_valid;
        req_valid[SRC_DECODE] = dec_valid;
        req_seq[SRC_BRANCH]   = br_seq;
        req_seq[SRC_DECODE]   = dec_seq;
    end

    sq_pick #(.SEQ_W(SEQ_W)) u_pick (
        .base       (oldest_seq),
        .live_valid (sq_valid),
        .live_seq   (sq_seq),
        .req_valid  (req_valid),
        .req_seq    (req_seq),
        .accept     (accept),
        .pick       (pick)
    );

    sq_fsm #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick       (pick),
        .br_seq     (br_seq),
        .br_target  (br_target),
        .dec_seq    (dec_seq),
        .dec_target (dec_target),
        .state      (state),
        .sq_seq     (sq_seq),
        .sq_target  (sq_target)
    );

    assign sq_valid = (state == ST_SQUASH);
endmodule

// File: rtl/squash_arbiter_chk.sv
module squash_arbiter_chk #(
    parameter int SEQ_W = 4,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEQ_W-1:0] oldest_seq,
    input logic             dec_valid,
    input logic [SEQ_W-1:0] dec_seq,
    input logic [PC_W-1:0]  dec_target,
    input logic             br_valid,
    input logic [SEQ_W-1:0] br_seq,
    input logic [PC_W-1:0]  br_target,
    input logic             sq_valid,
    input logic [SEQ_W-1:0] sq_seq,
    input logic [PC_W-1:0]  sq_target
);
    function automatic logic is_older(input logic [SEQ_W-1:0] a,
                                      input logic [SEQ_W-1:0] b,
                                      input logic [SEQ_W-1:0] base);
        logic [SEQ_W-1:0] da;
        logic [SEQ_W-1:0] db;
        da = a - base;
        db = b - base;
        return da < db;
    endfunction

    // R2
    a_r2_decode_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !br_valid && !sq_valid) |=>
            (sq_valid && sq_seq == $past(dec_seq) && sq_target == $past(dec_target)));

    // R3
    a_r3_branch_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !dec_valid && !sq_valid) |=>
            (sq_valid && sq_seq == $past(br_seq) && sq_target == $past(br_target)));

    // R4 / R5
    a_r4_older_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && dec_valid && !sq_valid && is_older(dec_seq, br_seq, oldest_seq)) |=>
            (sq_valid && sq_seq == $past(dec_seq)));

    // R7
    a_r7_drop_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !dec_valid) |=> !sq_valid);

    // R8
    a_r8_ignore_younger: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && dec_valid && !br_valid && !is_older(dec_seq, sq_seq, oldest_seq)) |=>
            !sq_valid);

    // R9
    a_r9_older_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && br_valid && !dec_valid && is_older(br_seq, sq_seq, oldest_seq)) |=>
            (sq_valid && sq_seq == $past(br_seq)));

    // R10
    a_r10_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_valid |-> ($stable(sq_seq) && $stable(sq_target)));
endmodule

bind squash_arbiter squash_arbiter_chk #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oldest_seq (oldest_seq),
    .dec_valid  (dec_valid),
    .dec_seq    (dec_seq),
    .dec_target (dec_target),
    .br_valid   (br_valid),
    .br_seq     (br_seq),
    .br_target  (br_target),
    .sq_valid   (sq_valid),
    .sq_seq     (sq_seq),
    .sq_target  (sq_target)
);

// File: tb/tb_squash_arbiter.sv
module tb_squash_arbiter;
    localparam int SEQ_W    = 4;
    localparam int PC_W     = 16;
    localparam int CLK_PER  = 10;

    typedef struct packed {
        logic             v;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  tgt;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SEQ_W-1:0] oldest_seq = '0;
    logic             dec_valid = 1'b0;
    logic [SEQ_W-1:0] dec_seq = '0;
    logic [PC_W-1:0]  dec_target = '0;
    logic             br_valid = 1'b0;
    logic [SEQ_W-1:0] br_seq = '0;
    logic [PC_W-1:0]  br_target = '0;
    logic             sq_valid;
    logic [SEQ_W-1:0] sq_seq;
    logic [PC_W-1:0]  sq_target;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  model = '0;

    always #(CLK_PER/2) clk = ~clk;

    squash_arbiter #(.SEQ_W(SEQ_W), .PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .oldest_seq(oldest_seq),
        .dec_valid(dec_valid), .dec_seq(dec_seq), .dec_target(dec_target),
        .br_valid(br_valid), .br_seq(br_seq), .br_target(br_target),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_target(sq_target)
    );

    function automatic bit older(input logic [SEQ_W-1:0] a,
                                 input logic [SEQ_W-1:0] b,
                                 input logic [SEQ_W-1:0] base);
        logic [SEQ_W-1:0] da;
        logic [SEQ_W-1:0] db;
        da = a - base;
        db = b - base;
        return da < db;
    endfunction

    task automatic check(input string tag, input exp_t got, input exp_t want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: actual v=%0b seq=%0d tgt=%h expected v=%0b seq=%0d tgt=%h",
                     tag, got.v, got.seq, got.tgt, want.v, want.seq, want.tgt);
        end
    endtask

    // Driver: applies one cycle of requests and pushes the expected result.
    task automatic drive(input bit bv, input int bs, input int bt,
                         input bit dv, input int ds, input int dt,
                         input int base, input string tag);
        bit   acc_b;
        bit   acc_d;
        exp_t nxt;
        @(negedge clk);
        br_valid   = bv;  br_seq  = SEQ_W'(bs); br_target  = PC_W'(bt);
        dec_valid  = dv;  dec_seq = SEQ_W'(ds); dec_target = PC_W'(dt);
        oldest_seq = SEQ_W'(base);
        acc_b = bv && (!model.v || older(SEQ_W'(bs), model.seq, SEQ_W'(base)));
        acc_d = dv && (!model.v || older(SEQ_W'(ds), model.seq, SEQ_W'(base)));
        nxt = model;
        nxt.v = 1'b0;
        if (acc_b && acc_d) begin
            if (older(SEQ_W'(ds), SEQ_W'(bs), SEQ_W'(base)))
                nxt = '{1'b1, SEQ_W'(ds), PC_W'(dt)};
            else
                nxt = '{1'b1, SEQ_W'(bs), PC_W'(bt)};
        end else if (acc_b) begin
            nxt = '{1'b1, SEQ_W'(bs), PC_W'(bt)};
        end else if (acc_d) begin
            nxt = '{1'b1, SEQ_W'(ds), PC_W'(dt)};
        end
        model = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compares one result per driven cycle, just after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  w;
            string t;
            w = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, '{sq_valid, sq_seq, sq_target}, w);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", '{sq_valid, sq_seq, sq_target}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", '{sq_valid, sq_seq, sq_target}, '0);

        drive(0, 0, 0, 1, 3, 'h100, 0, "R2 decode alone");
        idle("R7/R10 release and hold");
        drive(1, 5, 'h200, 0, 0, 0, 0, "R3 branch alone");
        idle("R7 release");
        drive(1, 6, 'h300, 1, 4, 'h310, 2, "R4 decode older");
        idle("R7");
        drive(1, 2, 'h400, 1, 9, 'h410, 0, "R4 branch older");
        idle("R10 hold");
        drive(1, 1, 'h500, 1, 15, 'h510, 14, "R5 wraparound age");
        idle("R7");
        drive(1, 7, 'h600, 1, 7, 'h610, 0, "R6 tie to branch");
        idle("R7");
        drive(0, 0, 0, 1, 3, 'h700, 0, "R2 setup");
        drive(1, 8, 'h710, 0, 0, 0, 0, "R8 younger ignored");
        drive(0, 0, 0, 1, 5, 'h720, 0, "R2 second");
        drive(1, 5, 'h730, 0, 0, 0, 0, "R8 equal ignored");
        drive(0, 0, 0, 1, 6, 'h800, 0, "R2 before override");
        drive(1, 2, 'h810, 0, 0, 0, 0, "R9 older overrides");
        idle("R7 after override");
        drive(1, 14, 'h900, 0, 0, 0, 12, "R3 near wrap");
        drive(0, 0, 0, 1, 1, 'h910, 12, "R8 R5 wrapped younger ignored");
        drive(1, 13, 'h920, 1, 15, 'h930, 12, "R4 R5 wrapped pair");
        idle("R10 final hold");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule